// File: doc/BRIEF.md
# Data Bus Line Tester

This block is a hardware self-test engine for a 64-bit memory data path. It finds shorted and open data lines. A single start pulse launches a fixed run of twelve routing-independent patterns. For each pattern the engine writes the pattern to a target word. It then writes a distinct guard word to the neighbouring address, so that a floating bus cannot hand the stale value back. Finally it reads the target exactly once and compares that one sample with the pattern.

The memory side is a plain synchronous port: address, write data, write enable, a read request, and read data qualified by a valid strobe. The read latency may vary. A failing pattern marks the run as failed but does not stop it. The first mismatch is captured: its address, the expected word and the word actually read. A one-cycle done pulse ends the run. An inject input flips one read bit, so that the detection path can be exercised on healthy memory.

Top module: `dbus_line_test`

## Requirements
- R1: With the default width, twelve patterns are applied in this order. For index k of 0..5, bit b of the pattern equals bit k of the number b (AAAA.., CCCC.., F0F0.., FF00.., FFFF0000FFFF0000, FFFFFFFF00000000). For k of 6..11, the pattern is the bitwise inverse of pattern 11-k (00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF.., 0F0F.., 3333.., 5555..).
- R2: Each pattern is handled on three consecutive cycles. The first writes the pattern to the base address. The second writes the guard 0x0123456789ABCDEF to the base address plus one, modulo 2^AW. The third raises the read request for the base address.
- R3: The read request is high for exactly one cycle per pattern and is never high together with write enable. The next pattern's write comes in the cycle after the valid read data is taken.
- R4: The compare happens only on a cycle where read-valid is high, for any read latency of one cycle or more.
- R5: A mismatch sets the fail level, and all twelve patterns are still applied after it.
- R6: On the first mismatch of a run, the engine captures the address, the expected pattern and the read value (after injection). These registers and the fail level hold until the next accepted start, and that start clears them to zero.
- R7: While inject is high, bit 15 of the read data is inverted before the compare and the capture.
- R8: After the last compare, done is high for exactly one cycle. Fail is valid in that cycle.
- R9: A start pulse that arrives while a run is in progress is ignored, including its base address.
- R10: After reset, done, fail, write enable, read request and the three capture registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_addr_i | input | AW | Target word address, sampled at start |
| inject_i | input | 1 | Invert read bit 15 before compare |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read request (one cycle) |
| mem_rdata_i | input | DW | Memory read data |
| mem_rvalid_i | input | 1 | Read data valid |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Run failed, held until next start |
| err_addr_o | output | AW | Address of first mismatch |
| err_exp_o | output | DW | Expected word of first mismatch |
| err_got_o | output | DW | Read word of first mismatch |

## Verification
Let E0 be the edge that samples start. The pattern write is on the bus in the cycle after E0, the guard write one cycle later, and the read request one cycle after that. With a read latency of L cycles, the compare happens 3+L edges after the start of each pattern. The capture registers and fail change at that compare edge, and done is high in the cycle that follows the last compare. The bench looks at the memory port on every falling edge and pops one expected bus operation from its scoreboard queue for each write or read it sees. It samples done, fail and the capture registers on falling edges only, so every value is read a half cycle after the edge that produced it.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPAT,
    ST_WGRD,
    ST_RREQ,
    ST_RWAIT,
    ST_DONE
  } seq_state_e;

  // Guard word nibble counted from the most significant end: 0,1,2,...,F,0,...
  function automatic logic [3:0] guard_nib(input int pos_from_msb);
    return 4'(pos_from_msb % 16);
  endfunction

endpackage

// File: rtl/dbt_seq.sv
module dbt_seq #(
  parameter int DW   = 64,
  parameter int AW   = 16,
  parameter int NPAT = 12,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          rvalid_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [DW-1:0] exp_o,
  output logic [AW-1:0] tgt_o,
  output logic          start_acc_o,
  output logic          cmp_evt_o,
  output logic          done_o
);
  import dbt_pkg::*;

  localparam int HALF = NPAT / 2;
  localparam int NNIB = DW / 4;
  localparam logic [AW-1:0] ONE_A    = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [IW-1:0] LAST_IDX = IW'(NPAT - 1);
  localparam logic [IW-1:0] ONE_I    = {{(IW-1){1'b0}}, 1'b1};

  function automatic logic [DW-1:0] walk_pat(input int k);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = ((b >> k) & 1) == 1;
    return r;
  endfunction

  function automatic logic [DW-1:0] pat_word(input int i);
    if (i < HALF) return walk_pat(i);
    return ~walk_pat(NPAT - 1 - i);
  endfunction

  function automatic logic [DW-1:0] guard_word();
    logic [DW-1:0] g;
    for (int n = 0; n < NNIB; n++) g[4*n +: 4] = guard_nib(NNIB - 1 - n);
    return g;
  endfunction

  localparam logic [DW-1:0] GUARD = guard_word();

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic          last_pat;
  logic          pat_wr;
  logic          rd_req;

  assign last_pat    = (idx_q == LAST_IDX);
  assign start_acc_o = (state_q == ST_IDLE) && start_i;
  assign cmp_evt_o   = (state_q == ST_RWAIT) && rvalid_i;
  assign pat_wr      = (state_q == ST_WPAT);
  assign rd_req      = (state_q == ST_RREQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_WPAT;
      ST_WPAT:  state_d = ST_WGRD;
      ST_WGRD:  state_d = ST_RREQ;
      ST_RREQ:  state_d = ST_RWAIT;
      ST_RWAIT: if (rvalid_i) state_d = last_pat ? ST_DONE : ST_WPAT;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_acc_o) begin
        idx_q  <= '0;
        base_q <= base_addr_i;
      end else if (cmp_evt_o && !last_pat) begin
        idx_q <= idx_q + ONE_I;
      end
    end
  end

  assign exp_o       = pat_word(int'(idx_q));
  assign tgt_o       = base_q;
  assign mem_we_o    = pat_wr || (state_q == ST_WGRD);
  assign mem_re_o    = rd_req;
  assign mem_addr_o  = (state_q == ST_WGRD) ? base_q + ONE_A : base_q;
  assign mem_wdata_o = (state_q == ST_WGRD) ? GUARD : exp_o;
  assign done_o      = (state_q == ST_DONE);

  assert_guard_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wr |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + ONE_A));
  assert_read_after_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !pat_wr) |=> (mem_re_o && !mem_we_o));
  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> !mem_re_o);
  assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/dbt_capture.sv
module dbt_capture #(
  parameter int DW = 64,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc_i,
  input  logic          cmp_evt_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] got_i,
  output logic          fail_o,
  output logic [AW-1:0] err_addr_o,
  output logic [DW-1:0] err_exp_o,
  output logic [DW-1:0] err_got_o
);
  logic miss;
  logic fail_q;

  assign miss = cmp_evt_i && (got_i != exp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q     <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_got_o  <= '0;
    end else if (start_acc_i) begin
      fail_q     <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_got_o  <= '0;
    end else if (miss) begin
      fail_q <= 1'b1;
      if (!fail_q) begin
        err_addr_o <= tgt_i;
        err_exp_o  <= exp_i;
        err_got_o  <= got_i;
      end
    end
  end

  assign fail_o = fail_q;

  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !start_acc_i) |=> fail_q);
  assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !start_acc_i) |=> ($stable(err_addr_o) && $stable(err_exp_o) && $stable(err_got_o)));
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_i |=> (!fail_q && err_got_o == '0));

endmodule

// File: rtl/dbus_line_test.sv
module dbus_line_test #(
  parameter int DW      = 64,
  parameter int AW      = 16,
  parameter int INJ_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          inject_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] err_addr_o,
  output logic [DW-1:0] err_exp_o,
  output logic [DW-1:0] err_got_o
);
  localparam int NPAT = 2 * $clog2(DW);
  localparam int IW   = $clog2(NPAT);
  localparam logic [DW-1:0] INJ_MASK = {{(DW-1){1'b0}}, 1'b1} << INJ_BIT;

  logic [DW-1:0] exp_w;
  logic [DW-1:0] got_w;
  logic [AW-1:0] tgt_w;
  logic          start_acc;
  logic          cmp_evt;

  assign got_w = mem_rdata_i ^ (inject_i ? INJ_MASK : '0);

  dbt_seq #(.DW(DW), .AW(AW), .NPAT(NPAT), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .rvalid_i    (mem_rvalid_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .exp_o       (exp_w),
    .tgt_o       (tgt_w),
    .start_acc_o (start_acc),
    .cmp_evt_o   (cmp_evt),
    .done_o      (done_o)
  );

  dbt_capture #(.DW(DW), .AW(AW)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_acc_i (start_acc),
    .cmp_evt_i   (cmp_evt),
    .tgt_i       (tgt_w),
    .exp_i       (exp_w),
    .got_i       (got_w),
    .fail_o      (fail_o),
    .err_addr_o  (err_addr_o),
    .err_exp_o   (err_exp_o),
    .err_got_o   (err_got_o)
  );

  assert_cmp_on_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> mem_rvalid_i);
  assert_done_after_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cmp_evt));

endmodule

// File: tb/tb_dbus_line_test.sv
module tb_dbus_line_test;
  localparam int DW = 64;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic          inject = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_rdata;
  logic          mem_rvalid;
  logic          done, fail;
  logic [AW-1:0] err_addr;
  logic [DW-1:0] err_exp, err_got;

  always #2 clk = ~clk;

  dbus_line_test dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_in),
    .inject_i(inject), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .mem_rvalid_i(mem_rvalid), .done_o(done), .fail_o(fail),
    .err_addr_o(err_addr), .err_exp_o(err_exp), .err_got_o(err_got)
  );

  localparam logic [DW-1:0] GUARD = 64'h0123456789ABCDEF;
  logic [DW-1:0] pats [12] = '{
    64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
    64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
    64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
    64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: variable latency, optional floating byte lane
  int            lat = 1;
  int            bad_lane = -1;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] lastw;
  logic          vpipe [8];
  logic [DW-1:0] dpipe [8];

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = mem[a[3:0]];
    if (bad_lane >= 0) r[bad_lane*8 +: 8] = lastw[bad_lane*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin vpipe[i] <= 1'b0; dpipe[i] <= '0; end
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      lastw <= '0;
    end else begin
      for (int i = 0; i < 7; i++) begin vpipe[i] <= vpipe[i+1]; dpipe[i] <= dpipe[i+1]; end
      vpipe[7] <= 1'b0;
      if (mem_re) begin
        vpipe[lat-1] <= 1'b1;
        dpipe[lat-1] <= rd_model(mem_addr);
      end
      if (mem_we) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        lastw <= mem_wdata;
      end
    end
  end
  assign mem_rvalid = vpipe[0];
  assign mem_rdata  = dpipe[0];

  // scoreboard
  typedef struct packed {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } op_t;
  op_t exq[$];

  task automatic push_run(input logic [AW-1:0] b);
    for (int p = 0; p < 12; p++) begin
      exq.push_back('{1'b1, b, pats[p]});
      exq.push_back('{1'b1, b + 16'd1, GUARD});
      exq.push_back('{1'b0, b, '0});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R5 unexpected bus operation", {48'd0, mem_addr}, '0);
      end else begin
        op_t e;
        e = exq.pop_front();
        chk(mem_we == e.we && !(mem_we && mem_re), "R3 operation kind", {63'd0, mem_we}, {63'd0, e.we});
        chk(mem_addr == e.a, "R2 address", {48'd0, mem_addr}, {48'd0, e.a});
        if (e.we) chk(mem_wdata == e.d, "R1 write data", mem_wdata, e.d);
      end
    end
  end

  task automatic run_case(input logic [AW-1:0] b, input int l, input int lane,
                          input bit inj, input bit poke);
    int w;
    lat = l; bad_lane = lane; inject = inj;
    push_run(b);
    @(negedge clk); base_in = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!fail && err_addr == '0 && err_got == '0, "R6 cleared by start", {63'd0, fail}, '0);
    if (poke) begin
      repeat (5) @(negedge clk);
      base_in = 16'h0003; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(done, "R8 done seen", {63'd0, done}, 64'd1);
    chk(exq.size() == 0, "R5 all patterns applied", 64'(exq.size()), 64'd0);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!done, "R8 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !fail && !mem_we && !mem_re, "R10 reset outputs", {60'd0, done, fail, mem_we, mem_re}, '0);
    chk(err_addr == '0 && err_exp == '0 && err_got == '0, "R10 reset capture", err_got, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // good run, latency 1
    run_case(16'h0010, 1, -1, 1'b0, 1'b0);
    chk(!fail, "R5 good run passes", {63'd0, fail}, '0);
    after_done();

    // good run, latency 4, wrapping guard address, start during run ignored (R9, R4)
    run_case(16'hFFFF, 4, -1, 1'b0, 1'b1);
    chk(!fail, "R4 long latency passes", {63'd0, fail}, '0);
    after_done();

    // injected bit 15 fault (R7)
    run_case(16'h0020, 2, -1, 1'b1, 1'b0);
    chk(fail, "R5 inject fails", {63'd0, fail}, 64'd1);
    chk(err_addr == 16'h0020, "R6 error address", {48'd0, err_addr}, 64'h20);
    chk(err_exp == pats[0], "R6 expected word", err_exp, pats[0]);
    chk(err_got == (pats[0] ^ 64'h8000), "R7 read word with inversion", err_got, pats[0] ^ 64'h8000);
    after_done();
    inject = 1'b0;
    repeat (6) @(negedge clk);
    chk(fail && err_got == (pats[0] ^ 64'h8000), "R6 capture holds", err_got, pats[0] ^ 64'h8000);

    // floating byte lane 6 shows guard byte 0x23
    run_case(16'h0005, 1, 6, 1'b0, 1'b0);
    chk(fail, "R5 lane fault fails", {63'd0, fail}, 64'd1);
    chk(err_got == 64'hAA23AAAAAAAAAAAA, "R6 lane fault read word", err_got, 64'hAA23AAAAAAAAAAAA);
    chk(err_addr == 16'h0005, "R6 lane fault address", {48'd0, err_addr}, 64'h5);
    after_done();

    // clean run after failure
    run_case(16'h0040, 3, -1, 1'b0, 1'b0);
    chk(!fail && err_exp == '0, "R6 clean run after failure", {63'd0, fail}, '0);
    after_done();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 50000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule